// File: doc/BRIEF.md
# Serial Audio Slave Receiver

This block receives a two-channel serial audio stream in the Philips I2S format while an external device drives the bit clock and word-select line. The three line signals are oversampled in the system clock domain through a synchronizer. The rising edges of the bit clock capture data most significant bit first. The bits are collected into 16-bit packets. Each finished packet goes into a single-entry receive buffer, where software reads it through a strobe-based read port.

Samples wider than 16 bits reach software as two consecutive packets: the upper half first, then the lower half. A sample trimmed to 16 bits inside a 32-bit channel gives one packet. Every packet carries a flag for the channel it came from. The block reports a buffer-full condition, an overrun, and a busy indication that follows each channel word. A single level interrupt request combines the receive and error conditions under two enable inputs.

Top module: `i2s_slave_rx`

## Requirements
- R1: After reset, rdata, rx_full, ovr_flag, busy and irq are all 0.
- R2: After enable, no packet is formed until the word-select line changes at a bit-clock rising edge. The bit captured at the next rising edge is the most significant bit of the new channel word, and bits follow MSB first.
- R3: With dlen_sel = 0 (16-bit data), each channel word gives exactly one packet holding its first 16 bits. Any further bits in a 32-bit channel are dropped.
- R4: With dlen_sel = 1 (24-bit data), a word gives two packets: bits 31..16 of the left-justified word, then bits 15..8 in packet bits 15..8 with zeros below. With dlen_sel = 2 or 3 (32-bit data), it gives the upper half and then the lower half.
- R5: A finished packet loads rdata and sets rx_full. A data_rd strobe clears rx_full.
- R6: chan_side is latched with every packet: 0 when the packet came from a word sent with word-select low (left), 1 when it came from a word sent with word-select high (right).
- R7: A packet that finishes while rx_full is 1 and no data_rd arrives in that cycle is discarded. The unread packet is kept and ovr_flag is set.
- R8: ovr_flag clears only at a stat_rd strobe that follows a data_rd made while ovr_flag was set. A stat_rd alone leaves it set.
- R9: irq is 1 exactly when (rx_ie and rx_full) or (err_ie and ovr_flag).
- R10: busy rises at the MSB edge of a channel word. It falls at the edge where word-select changes, so in continuous traffic it is low for one bit-clock period between words.
- R11: Driving en low forces busy low. Reception then needs a new word-select change before any packet is formed.
- R12: A data_rd in the same cycle as a finishing packet returns the old value. The new packet is loaded, rx_full stays 1 and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable |
| dlen_sel | input | 2 | Data length: 0 = 16, 1 = 24, 2/3 = 32 bits |
| rx_ie | input | 1 | Receive interrupt enable |
| err_ie | input | 1 | Overrun interrupt enable |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select (low = left) |
| sd_i | input | 1 | Serial data |
| data_rd | input | 1 | Read strobe for the data register |
| stat_rd | input | 1 | Read strobe for the status register |
| rdata | output | 16 | Oldest unread packet |
| rx_full | output | 1 | Receive buffer holds an unread packet |
| chan_side | output | 1 | Channel of the buffered packet |
| ovr_flag | output | 1 | Overrun occurred |
| busy | output | 1 | Channel word in progress |
| irq | output | 1 | Interrupt request |

## Verification
A packet can finish in the same system cycle that software reads the previous one. That cycle decides between a clean hand-over and an overrun. The bench first leaves one packet unread. During the last bit of the next word it raises data_rd exactly in the cycle the new packet lands, counting the synchronizer and framing registers. It takes the read value as correct only if it is the old packet, and then requires rx_full high, the new packet in rdata and ovr_flag low. A separate run with no read at that point must give an overrun that keeps the old packet.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
   localparam int PKT_W = 16;

   typedef enum logic [1:0] {
      DLEN_16 = 2'd0,
      DLEN_24 = 2'd1,
      DLEN_32 = 2'd2,
      DLEN_32B = 2'd3
   } dlen_e;

   function automatic int valid_bits(input dlen_e d);
      case (d)
         DLEN_16: valid_bits = 16;
         DLEN_24: valid_bits = 24;
         default: valid_bits = 32;
      endcase
   endfunction
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2s_rx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser
   import i2s_rx_pkg::*;
#(
   parameter int MAX_CH_BITS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [1:0]       dlen_sel,
   input  logic             sck_s,
   input  logic             ws_s,
   input  logic             sd_s,
   output logic             pkt_vld,
   output logic [PKT_W-1:0] pkt,
   output logic             pkt_side,
   output logic             busy
);
   localparam int CNT_W = $clog2(MAX_CH_BITS + 1);
   localparam logic [CNT_W-1:0] IDX_HI  = CNT_W'(PKT_W - 1);
   localparam logic [CNT_W-1:0] IDX_LO  = CNT_W'(2 * PKT_W - 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CH_BITS);

   if (MAX_CH_BITS < 2 * PKT_W) begin : g_bad_len
      $error("i2s_rx_deser: MAX_CH_BITS must cover two packets");
   end

   logic             sck_prev, ws_prev, synced, chan;
   logic [CNT_W-1:0] cnt;
   logic [PKT_W-1:0] shreg;
   logic             rise, ws_edge, bitv, two_pkts, at_boundary;
   logic [CNT_W-1:0] nvalid;

   assign rise        = sck_s & ~sck_prev;
   assign ws_edge     = ws_s ^ ws_prev;
   assign nvalid      = CNT_W'(valid_bits(dlen_e'(dlen_sel)));
   assign bitv        = (cnt < nvalid) ? sd_s : 1'b0;
   assign two_pkts    = (dlen_e'(dlen_sel) != DLEN_16);
   assign at_boundary = (cnt == IDX_HI) || (two_pkts && cnt == IDX_LO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         ws_prev  <= 1'b0;
         synced   <= 1'b0;
         chan     <= 1'b0;
         cnt      <= '0;
         shreg    <= '0;
         pkt      <= '0;
         pkt_side <= 1'b0;
         pkt_vld  <= 1'b0;
         busy     <= 1'b0;
      end else begin
         sck_prev <= sck_s;
         pkt_vld  <= 1'b0;
         if (rise) ws_prev <= ws_s;
         if (!en) begin
            synced <= 1'b0;
            busy   <= 1'b0;
            cnt    <= '0;
         end else if (rise) begin
            if (synced) begin
               shreg <= {shreg[PKT_W-2:0], bitv};
               if (at_boundary) begin
                  pkt_vld  <= 1'b1;
                  pkt      <= {shreg[PKT_W-2:0], bitv};
                  pkt_side <= chan;
               end
            end
            if (ws_edge) begin
               synced <= 1'b1;
               cnt    <= '0;
               busy   <= 1'b0;
               chan   <= ws_s;
            end else if (synced) begin
               busy <= 1'b1;
               if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assert_busy_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy);

   assert_busy_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && rise && ws_edge) |=> !busy);

   assert_sync_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !synced) |=> !pkt_vld);
endmodule

// File: rtl/i2s_rx_buf.sv
module i2s_rx_buf
   import i2s_rx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_vld,
   input  logic [PKT_W-1:0] pkt,
   input  logic             pkt_side,
   input  logic             data_rd,
   input  logic             stat_rd,
   input  logic             rx_ie,
   input  logic             err_ie,
   output logic [PKT_W-1:0] rdata,
   output logic             rx_full,
   output logic             chan_side,
   output logic             ovr_flag,
   output logic             irq
);
   logic clr_armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata     <= '0;
         rx_full   <= 1'b0;
         chan_side <= 1'b0;
         ovr_flag  <= 1'b0;
         clr_armed <= 1'b0;
      end else begin
         if (pkt_vld && (!rx_full || data_rd)) begin
            rdata     <= pkt;
            chan_side <= pkt_side;
            rx_full   <= 1'b1;
         end else if (data_rd) begin
            rx_full <= 1'b0;
         end
         if (data_rd && ovr_flag) clr_armed <= 1'b1;
         if (stat_rd && clr_armed) begin
            ovr_flag  <= 1'b0;
            clr_armed <= 1'b0;
         end
         if (pkt_vld && rx_full && !data_rd) ovr_flag <= 1'b1;
      end
   end

   assign irq = (rx_ie & rx_full) | (err_ie & ovr_flag);

   assert_rx_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && !rx_full) |=> (rx_full && rdata == $past(pkt)));

   assert_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !pkt_vld) |=> !rx_full);

   assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && rx_full && !data_rd) |=> (ovr_flag && $stable(rdata)));

   assert_coincide_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_vld && rx_full && data_rd && !ovr_flag) |=> (rx_full && !ovr_flag));

   assert_stat_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !clr_armed && !data_rd) |=> ovr_flag);

   assert_irq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ovr_flag) && err_ie) |-> irq);
endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
   import i2s_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_CH_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        dlen_sel,
   input  logic              rx_ie,
   input  logic              err_ie,
   input  logic              sck_i,
   input  logic              ws_i,
   input  logic              sd_i,
   input  logic              data_rd,
   input  logic              stat_rd,
   output logic [PKT_W-1:0]  rdata,
   output logic              rx_full,
   output logic              chan_side,
   output logic              ovr_flag,
   output logic              busy,
   output logic              irq
);
   logic [2:0]       line_s;
   logic             pkt_vld, pkt_side;
   logic [PKT_W-1:0] pkt;

   i2s_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sck_i, ws_i, sd_i}),
      .q     (line_s)
   );

   i2s_rx_deser #(.MAX_CH_BITS(MAX_CH_BITS)) u_deser (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .dlen_sel (dlen_sel),
      .sck_s    (line_s[2]),
      .ws_s     (line_s[1]),
      .sd_s     (line_s[0]),
      .pkt_vld  (pkt_vld),
      .pkt      (pkt),
      .pkt_side (pkt_side),
      .busy     (busy)
   );

   i2s_rx_buf u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .pkt_vld   (pkt_vld),
      .pkt       (pkt),
      .pkt_side  (pkt_side),
      .data_rd   (data_rd),
      .stat_rd   (stat_rd),
      .rx_ie     (rx_ie),
      .err_ie    (err_ie),
      .rdata     (rdata),
      .rx_full   (rx_full),
      .chan_side (chan_side),
      .ovr_flag  (ovr_flag),
      .irq       (irq)
   );
endmodule

// File: tb/i2s_slave_rx_tb.sv
module i2s_slave_rx_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic [1:0] dlen_sel = 2'd0;
   logic rx_ie = 1'b0, err_ie = 1'b0;
   logic sck_i = 1'b0, ws_i = 1'b1, sd_i = 1'b0;
   logic data_rd = 1'b0, stat_rd = 1'b0;
   logic [15:0] rdata;
   logic rx_full, chan_side, ovr_flag, busy, irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   logic [15:0] cap_val;

   always #5 clk = ~clk;

   i2s_slave_rx dut_i (
      .clk(clk), .rst_n(rst_n), .en(en), .dlen_sel(dlen_sel),
      .rx_ie(rx_ie), .err_ie(err_ie), .sck_i(sck_i), .ws_i(ws_i),
      .sd_i(sd_i), .data_rd(data_rd), .stat_rd(stat_rd), .rdata(rdata),
      .rx_full(rx_full), .chan_side(chan_side), .ovr_flag(ovr_flag),
      .busy(busy), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic w, input logic d, input logic cap);
      ws_i = w; sd_i = d; sck_i = 1'b0;
      repeat (4) @(negedge clk);
      sck_i = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (cap && k == 3) begin cap_val = rdata; data_rd = 1'b1; end
         if (k == 4) data_rd = 1'b0;
      end
   endtask

   task automatic read_data();
      @(negedge clk); cap_val = rdata; data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0;
   endtask

   task automatic read_stat();
      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
   endtask

   task automatic resync(input logic c);
      en = 1'b0; repeat (3) @(negedge clk); en = 1'b1;
      send_bit(~c, 1'b0, 1'b0);
      send_bit(c, 1'b0, 1'b0);
   endtask

   // word is left-justified in w; optional mid-word check of the first packet
   task automatic send_word(input logic c, input logic nc, input logic [31:0] w,
                            input int nbits, input bit mid, input logic [15:0] mid_exp,
                            input bit cap_last);
      for (int i = 0; i < nbits; i++) begin
         send_bit((i == nbits - 1) ? nc : c, w[31 - i], cap_last && (i == nbits - 1));
         if (i == 0) chk("R10 busy after MSB", 32'(busy), 32'd1);
         if (mid && i == 15) begin
            chk("R4 first packet", 32'(rdata), 32'(mid_exp));
            chk("R6 side first packet", 32'(chan_side), 32'(c));
            read_data();
         end
      end
      chk("R10 busy low at word end", 32'(busy), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 rdata", 32'(rdata), 32'd0);
      chk("R1 rx_full", 32'(rx_full), 32'd0);
      chk("R1 ovr", 32'(ovr_flag), 32'd0);
      chk("R1 busy", 32'(busy), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
   endtask

   task automatic t_basic16();
      dlen_sel = 2'd0; rx_ie = 1'b1; err_ie = 1'b0;
      resync(1'b0);
      send_word(1'b0, 1'b1, 32'hA5C3_0000, 16, 0, 16'h0, 0);
      chk("R2 R3 left data MSB first", 32'(rdata), 32'h0000A5C3);
      chk("R5 full set", 32'(rx_full), 32'd1);
      chk("R6 left side", 32'(chan_side), 32'd0);
      chk("R9 irq rx", 32'(irq), 32'd1);
      read_data();
      chk("R5 full cleared", 32'(rx_full), 32'd0);
      chk("R9 irq cleared", 32'(irq), 32'd0);
      send_word(1'b1, 1'b0, 32'h1234_0000, 16, 0, 16'h0, 0);
      chk("R3 right data", 32'(rdata), 32'h00001234);
      chk("R6 right side", 32'(chan_side), 32'd1);
      read_data();
      rx_ie = 1'b0;
   endtask

   task automatic t_ch32_d16();
      dlen_sel = 2'd0;
      resync(1'b0);
      send_word(1'b0, 1'b1, 32'hDEAD_BEEF, 32, 1, 16'hDEAD, 0);
      chk("R3 no second packet", 32'(rx_full), 32'd0);
      chk("R3 ovr untouched", 32'(ovr_flag), 32'd0);
   endtask

   task automatic t_d24();
      dlen_sel = 2'd1;
      resync(1'b1);
      send_word(1'b1, 1'b0, 32'hABCD_EF5A, 32, 1, 16'hABCD, 0);
      chk("R4 24-bit low packet", 32'(rdata), 32'h0000EF00);
      chk("R6 right second packet", 32'(chan_side), 32'd1);
      read_data();
   endtask

   task automatic t_d32();
      dlen_sel = 2'd2;
      resync(1'b0);
      send_word(1'b0, 1'b1, 32'h89AB_CDEF, 32, 1, 16'h89AB, 0);
      chk("R4 32-bit low packet", 32'(rdata), 32'h0000CDEF);
      chk("R6 left second packet", 32'(chan_side), 32'd0);
      read_data();
   endtask

   task automatic t_overrun();
      dlen_sel = 2'd0; rx_ie = 1'b0; err_ie = 1'b1;
      resync(1'b0);
      send_word(1'b0, 1'b1, 32'h1111_0000, 16, 0, 16'h0, 0);
      chk("R9 irq gated by rx_ie", 32'(irq), 32'd0);
      send_word(1'b1, 1'b0, 32'h2222_0000, 16, 0, 16'h0, 0);
      chk("R7 ovr set", 32'(ovr_flag), 32'd1);
      chk("R7 old packet kept", 32'(rdata), 32'h00001111);
      chk("R7 old side kept", 32'(chan_side), 32'd0);
      chk("R9 irq err", 32'(irq), 32'd1);
      read_stat();
      chk("R8 status alone keeps ovr", 32'(ovr_flag), 32'd1);
      read_data();
      chk("R7 read returns old", 32'(cap_val), 32'h00001111);
      chk("R8 data read keeps ovr", 32'(ovr_flag), 32'd1);
      read_stat();
      chk("R8 ovr cleared", 32'(ovr_flag), 32'd0);
      chk("R9 irq off", 32'(irq), 32'd0);
      err_ie = 1'b0;
   endtask

   task automatic t_coincide();
      dlen_sel = 2'd0;
      resync(1'b0);
      send_word(1'b0, 1'b1, 32'hAAAA_0000, 16, 0, 16'h0, 0);
      send_word(1'b1, 1'b0, 32'h5555_0000, 16, 0, 16'h0, 1);
      chk("R12 old value read", 32'(cap_val), 32'h0000AAAA);
      chk("R12 full stays", 32'(rx_full), 32'd1);
      chk("R12 new loaded", 32'(rdata), 32'h00005555);
      chk("R12 no overrun", 32'(ovr_flag), 32'd0);
      read_data();
   endtask

   task automatic t_disable();
      dlen_sel = 2'd0;
      resync(1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b1, 1'b0);
      chk("R10 busy mid word", 32'(busy), 32'd1);
      en = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 busy forced low", 32'(busy), 32'd0);
      en = 1'b1;
      for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b1, 1'b0);
      chk("R11 R2 no packet before ws change", 32'(rx_full), 32'd0);
      chk("R11 busy stays low", 32'(busy), 32'd0);
      send_bit(1'b1, 1'b0, 1'b0);
      send_word(1'b1, 1'b0, 32'hC0DE_0000, 16, 0, 16'h0, 0);
      chk("R2 resync data", 32'(rdata), 32'h0000C0DE);
      read_data();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic16();
      t_ch32_d16();
      t_d24();
      t_d32();
      t_overrun();
      t_coincide();
      t_disable();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule